// File: doc/BRIEF.md
# Auxiliary Channel Ownership Arbiter

This block decides which of two masters may drive a shared auxiliary channel register interface: the host software port or an embedded microcontroller port. Each master asks for the channel with a one-cycle request pulse and gives it back with a one-cycle done pulse. The current owner is reported on a 2-bit status output that both masters can read. A master confirms its grant by seeing its own code on that output.

The channel core starts out disabled. The first software request that finds the core disabled does not get the grant at once. The block first raises the core enable and asserts the core reset. It waits for the core to report reset-done, removes the reset, and waits for reset-done to clear. Only after that is the software grant given. Once enabled, the core stays enabled until the block is reset.

Top module: `aux_chan_arbiter`

## Requirements
- R1: After reset, `own_status` reads 0 (free), and `chan_en` and `chan_rst` are 0. `own_status` only takes the values 0 (free), 1 (software owns) and 2 (microcontroller owns), and never 3.
- R2: A `sw_req` pulse while the microcontroller owns the channel is refused. `own_status` stays 2, and the pulse does not start the enable sequence.
- R3: A `sw_req` pulse while the channel is free and the core is already enabled makes `own_status` read 1 after the next rising edge.
- R4: A `sw_req` pulse that finds the core disabled sets `chan_en` and `chan_rst` to 1 after that edge. `chan_rst` holds at 1 until `chan_rst_done` has been sampled high, and drops at the following edge; with a core latency of L cycles this is L+1 edges after the request.
- R5: The software grant is withheld until the reset handshake finishes. `own_status` changes to 1 at the second rising edge after `chan_rst_done` is sampled low again; with core latency L this is 2L+3 edges after the request.
- R6: A `sw_done` pulse while software owns the channel makes `own_status` read 0 after the next edge. `chan_en` stays 1.
- R7: A `mcu_req` pulse while the channel is free makes `own_status` read 2 after the next edge, and does not start the enable sequence. When `sw_req` and `mcu_req` arrive in the same cycle on a free channel, the microcontroller wins.
- R8: A `mcu_done` pulse while the microcontroller owns the channel makes `own_status` read 0 after the next edge.
- R9: A done pulse from the master that does not own the channel is ignored, and `own_status` is unchanged.
- R10: Once `chan_en` is 1 it stays 1 until reset. Later software requests do not pulse `chan_rst` again.
- R11: If the microcontroller takes the free channel while a software request waits on the enable sequence, that software request is dropped. It is not granted after the microcontroller releases the channel.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| sw_req | input | 1 | Software request pulse |
| sw_done | input | 1 | Software release pulse |
| mcu_req | input | 1 | Microcontroller request pulse |
| mcu_done | input | 1 | Microcontroller release pulse |
| chan_rst_done | input | 1 | Reset-done indication from the channel core |
| chan_en | output | 1 | Enable to the channel core |
| chan_rst | output | 1 | Reset to the channel core |
| own_status | output | 2 | Owner: 0 free, 1 software, 2 microcontroller |

## Verification
A corrupted owner register appears on `own_status` in the same cycle, because the status output is that register with no logic in between. A wrong enable sequencer state shows up as a `chan_rst` edge at the wrong time, or as a grant that arrives earlier or later than 2L+3 edges. The bench counts these edges exactly. A lost or stale pending software request shows as a grant that appears or goes missing within a few cycles after the microcontroller releases the channel.

// File: rtl/aux_arb_pkg.sv
package aux_arb_pkg;

   localparam int unsigned OWN_W = 2;

   typedef enum logic [OWN_W-1:0] {
      OWN_FREE = 2'd0,
      OWN_SW   = 2'd1,
      OWN_MCU  = 2'd2
   } own_e;

   typedef enum logic [1:0] {
      SEQ_OFF   = 2'd0,
      SEQ_RST   = 2'd1,
      SEQ_UNRST = 2'd2,
      SEQ_READY = 2'd3
   } seq_e;

endpackage

// File: rtl/aux_en_seq.sv
module aux_en_seq
   import aux_arb_pkg::*;
#(
   parameter bit HAS_CHAN_RESET = 1'b1
) (
   input  logic clk,
   input  logic rst_n,
   input  logic kick,
   input  logic rst_done,
   output logic en,
   output logic core_rst,
   output logic ready
);

   generate
      if (HAS_CHAN_RESET) begin : g_handshake
         seq_e state_q, state_d;

         always_comb begin
            state_d = state_q;
            unique case (state_q)
               SEQ_OFF:   if (kick)      state_d = SEQ_RST;
               SEQ_RST:   if (rst_done)  state_d = SEQ_UNRST;
               SEQ_UNRST: if (!rst_done) state_d = SEQ_READY;
               default:                  state_d = SEQ_READY;
            endcase
         end

         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) state_q <= SEQ_OFF;
            else        state_q <= state_d;
         end

         assign en       = (state_q != SEQ_OFF);
         assign core_rst = (state_q == SEQ_RST);
         assign ready    = (state_q == SEQ_READY);

         // R4: reset is held while the core has not reported done
         p_rst_hold_r4: assert property (@(posedge clk) disable iff (!rst_n)
            (core_rst && !rst_done) |=> core_rst);
         // R4: reset is released once done has been seen
         p_rst_drop_r4: assert property (@(posedge clk) disable iff (!rst_n)
            (core_rst && rst_done) |=> !core_rst);
         // R5: ready only after done has gone low with reset released
         p_ready_after_unrst_r5: assert property (@(posedge clk) disable iff (!rst_n)
            $rose(ready) |-> ($past(!rst_done) && $past(en) && !$past(core_rst)));
      end else begin : g_plain
         logic en_q;

         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)    en_q <= 1'b0;
            else if (kick) en_q <= 1'b1;
         end

         assign en       = en_q;
         assign core_rst = 1'b0;
         assign ready    = en_q;
      end
   endgenerate

   // R10: enable is sticky
   p_en_sticky_r10: assert property (@(posedge clk) disable iff (!rst_n)
      en |=> en);
   // R4: reset to the core only while it is enabled
   p_rst_needs_en_r4: assert property (@(posedge clk) disable iff (!rst_n)
      core_rst |-> en);

endmodule

// File: rtl/aux_req_pick.sv
module aux_req_pick #(
   parameter bit MCU_WINS = 1'b1
) (
   input  logic is_free,
   input  logic sw_want,
   input  logic mcu_want,
   output logic take_sw,
   output logic take_mcu
);

   generate
      if (MCU_WINS) begin : g_mcu_first
         assign take_mcu = is_free && mcu_want;
         assign take_sw  = is_free && sw_want && !mcu_want;
      end else begin : g_sw_first
         assign take_sw  = is_free && sw_want;
         assign take_mcu = is_free && mcu_want && !sw_want;
      end
   endgenerate

   always_comb begin
      a_pick_excl_r7: assert (!(take_sw && take_mcu));
   end

endmodule

// File: rtl/aux_own_ctl.sv
module aux_own_ctl
   import aux_arb_pkg::*;
#(
   parameter bit MCU_WINS = 1'b1
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             sw_req,
   input  logic             sw_done,
   input  logic             mcu_req,
   input  logic             mcu_done,
   input  logic             chan_ready,
   output logic             seq_kick,
   output logic [OWN_W-1:0] owner
);

   own_e own_q, own_d;
   logic pend_q, pend_d;
   logic is_free, sw_want, take_sw, take_mcu;

   assign is_free = (own_q == OWN_FREE);
   assign sw_want = sw_req || pend_q;

   aux_req_pick #(.MCU_WINS(MCU_WINS)) u_pick (
      .is_free (is_free),
      .sw_want (sw_want),
      .mcu_want(mcu_req),
      .take_sw (take_sw),
      .take_mcu(take_mcu)
   );

   assign seq_kick = take_sw && !chan_ready;

   always_comb begin
      own_d  = own_q;
      pend_d = pend_q;
      unique case (own_q)
         OWN_SW:  if (sw_done)  own_d = OWN_FREE;
         OWN_MCU: if (mcu_done) own_d = OWN_FREE;
         default: begin
            if (take_mcu) begin
               own_d  = OWN_MCU;
               pend_d = 1'b0;
            end else if (take_sw) begin
               if (chan_ready) begin
                  own_d  = OWN_SW;
                  pend_d = 1'b0;
               end else begin
                  pend_d = 1'b1;
               end
            end
         end
      endcase
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         own_q  <= OWN_FREE;
         pend_q <= 1'b0;
      end else begin
         own_q  <= own_d;
         pend_q <= pend_d;
      end
   end

   assign owner = own_q;

   p_legal_code_r1: assert property (@(posedge clk) disable iff (!rst_n)
      owner != 2'd3);
   p_mcu_keeps_r2: assert property (@(posedge clk) disable iff (!rst_n)
      (own_q == OWN_MCU && !mcu_done) |=> own_q == OWN_MCU);
   p_grant_needs_ready_r5: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(own_q == OWN_SW) |-> $past(chan_ready));
   p_sw_release_r6: assert property (@(posedge clk) disable iff (!rst_n)
      (own_q == OWN_SW && sw_done) |=> own_q == OWN_FREE);
   p_mcu_take_r7: assert property (@(posedge clk) disable iff (!rst_n)
      (own_q == OWN_FREE && mcu_req && MCU_WINS) |=> own_q == OWN_MCU);
   p_mcu_release_r8: assert property (@(posedge clk) disable iff (!rst_n)
      (own_q == OWN_MCU && mcu_done) |=> own_q == OWN_FREE);
   p_foreign_done_r9: assert property (@(posedge clk) disable iff (!rst_n)
      (own_q == OWN_SW && !sw_done) |=> own_q == OWN_SW);
   p_pend_dropped_r11: assert property (@(posedge clk) disable iff (!rst_n)
      (own_q == OWN_MCU) |-> !pend_q);

endmodule

// File: rtl/aux_chan_arbiter.sv
module aux_chan_arbiter
   import aux_arb_pkg::*;
#(
   parameter bit          HAS_CHAN_RESET = 1'b1,
   parameter bit          MCU_WINS       = 1'b1,
   parameter int unsigned STATUS_W       = 2
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic                sw_req,
   input  logic                sw_done,
   input  logic                mcu_req,
   input  logic                mcu_done,
   input  logic                chan_rst_done,
   output logic                chan_en,
   output logic                chan_rst,
   output logic [STATUS_W-1:0] own_status
);

   localparam int unsigned PAD_W = STATUS_W - OWN_W;

   generate
      if (STATUS_W < OWN_W) begin : g_bad_width
         $error("STATUS_W must be at least the owner code width");
      end
   endgenerate

   logic             ready, kick;
   logic [OWN_W-1:0] owner;

   aux_en_seq #(.HAS_CHAN_RESET(HAS_CHAN_RESET)) u_seq (
      .clk     (clk),
      .rst_n   (rst_n),
      .kick    (kick),
      .rst_done(chan_rst_done),
      .en      (chan_en),
      .core_rst(chan_rst),
      .ready   (ready)
   );

   aux_own_ctl #(.MCU_WINS(MCU_WINS)) u_own (
      .clk       (clk),
      .rst_n     (rst_n),
      .sw_req    (sw_req),
      .sw_done   (sw_done),
      .mcu_req   (mcu_req),
      .mcu_done  (mcu_done),
      .chan_ready(ready),
      .seq_kick  (kick),
      .owner     (owner)
   );

   generate
      if (PAD_W > 0) begin : g_pad
         assign own_status = {{PAD_W{1'b0}}, owner};
      end else begin : g_exact
         assign own_status = owner;
      end
   endgenerate

   // R2: a refused software request must not enable the core
   p_refuse_no_seq_r2: assert property (@(posedge clk) disable iff (!rst_n)
      (owner == OWN_MCU && !chan_en) |=> !chan_en);

endmodule

// File: tb/aux_chan_arbiter_bench.sv
module aux_chan_arbiter_bench;

   localparam int CLK_PERIOD = 10;
   localparam int CORE_LAT   = 4;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic sw_req = 1'b0, sw_done = 1'b0, mcu_req = 1'b0, mcu_done = 1'b0;
   logic chan_rst_done;
   logic chan_en, chan_rst;
   logic [1:0] own_status;
   logic [CORE_LAT-1:0] core_pipe;

   int errors = 0;
   int checks = 0;
   bit finished = 1'b0;

   always #(CLK_PERIOD/2) clk = ~clk;

   // channel core model: reset-done follows reset after CORE_LAT edges
   always @(posedge clk or negedge rst_n) begin
      if (!rst_n) core_pipe <= '0;
      else        core_pipe <= {core_pipe[CORE_LAT-2:0], chan_rst};
   end
   assign chan_rst_done = core_pipe[CORE_LAT-1];

   aux_chan_arbiter u_aux_chan_arbiter (
      .clk          (clk),
      .rst_n        (rst_n),
      .sw_req       (sw_req),
      .sw_done      (sw_done),
      .mcu_req      (mcu_req),
      .mcu_done     (mcu_done),
      .chan_rst_done(chan_rst_done),
      .chan_en      (chan_en),
      .chan_rst     (chan_rst),
      .own_status   (own_status)
   );

   task automatic check(input string req, input int act, input int exp);
      checks++;
      if (act != exp) begin
         errors++;
         $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
      end
   endtask

   task automatic step(input logic s_rq, input logic s_dn, input logic m_rq, input logic m_dn);
      sw_req = s_rq; sw_done = s_dn; mcu_req = m_rq; mcu_done = m_dn;
      @(posedge clk);
      @(negedge clk);
      sw_req = 1'b0; sw_done = 1'b0; mcu_req = 1'b0; mcu_done = 1'b0;
   endtask

   task automatic do_reset();
      rst_n = 1'b0;
      repeat (2) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
   endtask

   // expected owner after one edge, channel already enabled
   function automatic int next_owner(input int cur, input bit s_rq, input bit s_dn,
                                     input bit m_rq, input bit m_dn);
      if (cur == 1) return s_dn ? 0 : 1;
      if (cur == 2) return m_dn ? 0 : 2;
      if (m_rq) return 2;
      if (s_rq) return 1;
      return 0;
   endfunction

   initial begin
      int grant_at, rst_fall_at, exp_own, seed_v;
      bit rst_pulsed;
      do_reset();
      // R1
      check("R1 reset status", own_status, 0);
      check("R1 reset en", chan_en, 0);
      check("R1 reset rst", chan_rst, 0);

      // R7: microcontroller takes free channel, no enable sequence
      step(0, 0, 1, 0);
      check("R7 mcu take", own_status, 2);
      check("R7 no enable", chan_en, 0);
      // R2: software refused
      step(1, 0, 0, 0);
      check("R2 refused status", own_status, 2);
      check("R2 no enable", chan_en, 0);
      // R9: foreign release ignored
      step(0, 1, 0, 0);
      check("R9 sw_done ignored", own_status, 2);
      // R8
      step(0, 0, 0, 1);
      check("R8 mcu release", own_status, 0);

      // R4/R5 enable handshake
      step(1, 0, 0, 0);
      check("R4 en raised", chan_en, 1);
      check("R4 rst raised", chan_rst, 1);
      check("R5 no early grant", own_status, 0);
      grant_at = -1; rst_fall_at = -1;
      for (int k = 1; k <= 40; k++) begin
         step(0, 0, 0, 0);
         if (rst_fall_at < 0 && !chan_rst) rst_fall_at = k;
         if (grant_at < 0 && own_status == 2'd1) grant_at = k;
      end
      check("R4 rst fall edge", rst_fall_at, CORE_LAT + 1);
      check("R5 grant edge", grant_at, 2*CORE_LAT + 3);

      // R6
      step(0, 1, 0, 0);
      check("R6 sw release", own_status, 0);
      check("R6 still enabled", chan_en, 1);
      // R3 / R10
      step(1, 0, 0, 0);
      check("R3 direct grant", own_status, 1);
      check("R10 no new reset", chan_rst, 0);
      step(0, 0, 0, 1);
      check("R9 mcu_done ignored", own_status, 1);
      step(1, 0, 0, 0);
      check("R3 repeat request", own_status, 1);
      step(0, 1, 0, 0);
      check("R6 release again", own_status, 0);
      // R7 tie
      step(1, 0, 1, 0);
      check("R7 tie mcu wins", own_status, 2);
      step(0, 0, 0, 1);
      check("R8 release after tie", own_status, 0);

      // R11: pending software request dropped
      do_reset();
      step(1, 0, 0, 0);
      check("R4 second seq rst", chan_rst, 1);
      step(0, 0, 1, 0);
      check("R11 mcu takes", own_status, 2);
      rst_pulsed = 1'b0;
      for (int k = 0; k < 15; k++) begin
         step(0, 0, 0, 0);
         check("R11 mcu keeps", own_status, 2);
      end
      check("R10 en after seq", chan_en, 1);
      step(0, 0, 0, 1);
      check("R11 free after release", own_status, 0);
      step(0, 0, 0, 0);
      check("R11 pending dropped", own_status, 0);

      // random traffic on enabled channel
      seed_v = $urandom(32'h1A5F);
      exp_own = 0;
      for (int n = 0; n < 500; n++) begin
         bit a, b, c, d;
         a = ($urandom % 10) < 3; b = ($urandom % 10) < 3;
         c = ($urandom % 10) < 3; d = ($urandom % 10) < 3;
         exp_own = next_owner(exp_own, a, b, c, d);
         step(a, b, c, d);
         check("R1 R3 R7 random owner", own_status, exp_own);
         if (chan_rst) rst_pulsed = 1'b1;
      end
      check("R10 no reset in random", rst_pulsed, 0);

      if (!finished) begin
         finished = 1'b1;
         $display("Result: errors=%0d of %0d checks", errors, checks);
         $finish;
      end
   end

   initial begin
      repeat (200000) @(posedge clk);
      if (!finished) begin
         finished = 1'b1;
         errors++;
         checks++;
         $display("FAIL watchdog: actual=timeout expected=completion");
         $display("Result: errors=%0d of %0d checks", errors, checks);
         $finish;
      end
   end

endmodule